// File: doc/BRIEF.md
# Element Packing Address Generator

This block turns the index of one user element into the list of memory reads needed to fetch that element. The memory is organised as data sets of S bits, and the user element is U bits wide. Both sizes are runtime inputs from 1 to `MAX_BITS`. The caller chooses one of three arrangements.

- **Padded:** each element gets its own whole number of data sets, starting at offset zero.
- **Packed:** elements are laid back to back as one bit stream, so an element can cross set boundaries.
- **Hybrid:** as many whole elements as fit share one set when U is at most S, and the padded layout is used when U is larger.

A start pulse launches a sequence. On each following cycle the block presents one access, made of a set index, a starting bit offset inside that set and a bit count. The final access of the element is flagged. The memory itself and the data movement are handled elsewhere. A chip uses this block in front of a narrow-word store to hide the element-to-set mapping from the requester.

Top module: `elem_pack_addr_gen`

## Requirements
- R1: After reset, `busy`, `acc_valid`, `acc_last` and `size_err` are all 0.
- R2: When U equals S, every policy produces exactly one access with set = index, offset 0 and count U.
- R3: Policy code 2'b00 (padded) and the reserved code 2'b11 produce k = ceil(U/S) accesses. They go to sets index·k through index·k+k-1, all at offset 0. Each count is S, except the last count, which is U-(k-1)·S.
- R4: Policy code 2'b01 (packed) starts at bit address index·U, in set (index·U)/S at offset (index·U) mod S. There is one access per spanned set. The first count is min(S-offset, U), later accesses start at offset 0, and no access extends past bit S of its set.
- R5: Under the packed policy, the number of accesses depends on the index. For example, with U=24 and S=32, index 0 needs one access and index 1 needs two.
- R6: Policy code 2'b10 (hybrid) with U ≤ S gives one access. Using p = floor(S/U), the set is index/p, the offset is (index mod p)·U and the count is U.
- R7: Policy code 2'b10 with U > S produces the same access list as the padded policy.
- R8: `acc_last` is 1 on the final access of a sequence only, and `busy` is 0 in the cycle after it.
- R9: A start pulse while `busy` is 1 is ignored, and the running sequence continues unchanged.
- R10: A start while idle with U=0 or S=0 sets `size_err` and launches no access. `size_err` stays set until the next accepted start, which clears it.
- R11: Accesses come one per clock, the first in the cycle after the accepting clock edge. `acc_valid` equals `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, sampled when idle |
| elem_idx | input | IDX_W | User element index |
| policy | input | 2 | 00 padded, 01 packed, 10 hybrid, 11 as padded |
| elem_bits | input | $clog2(MAX_BITS+1) | User element size U |
| set_bits | input | $clog2(MAX_BITS+1) | Data-set width S |
| acc_valid | output | 1 | An access is presented |
| acc_set | output | IDX_W+$clog2(MAX_BITS+1) | Data-set index |
| acc_offset | output | $clog2(MAX_BITS) | Starting bit inside the set |
| acc_count | output | $clog2(MAX_BITS+1) | Bits taken from the set |
| acc_last | output | 1 | Final access of the element |
| busy | output | 1 | Sequence in progress |
| size_err | output | 1 | Last idle start had a zero size |

## Verification
The bench uses the defaults `IDX_W=16` and `MAX_BITS=64`. These values allow the extreme case of a 64-bit element read through 8-bit sets, which takes eight accesses. They also allow a 23-bit set index that no truncation may clip. Odd sizes such as U=20 and S=7 exercise packed elements that cross three set boundaries. U=10 and S=32 leave two unused bits per set under the hybrid policy.

// File: rtl/epag_pkg.sv
// Shared definitions for the element packing address generator.
package epag_pkg;
    // Arrangement policy codes as seen on the policy port.
    typedef enum logic [1:0] {
        POL_PAD = 2'b00,
        POL_CAT = 2'b01,
        POL_HYB = 2'b10,
        POL_RSV = 2'b11
    } pack_pol_e;
endpackage

// File: rtl/epag_origin.sv
// epag_origin: combinational start-point calculator.
// Given an element index, the policy and the two sizes, it returns the
// data set and bit offset where the element begins. Assumes the caller
// only uses the result when both sizes are non-zero; zero divisors are
// replaced by one so the arithmetic stays defined.
module epag_origin
    import epag_pkg::*;
#(
    parameter int IDX_W    = 16,
    parameter int MAX_BITS = 64,
    localparam int SZ_W    = $clog2(MAX_BITS + 1),
    localparam int SET_W   = IDX_W + SZ_W
) (
    input  logic [IDX_W-1:0] idx,
    input  pack_pol_e        pol,
    input  logic [SZ_W-1:0]  u,
    input  logic [SZ_W-1:0]  s,
    output logic [SET_W-1:0] first_set,
    output logic [SZ_W-1:0]  first_off
);
    logic [SET_W-1:0] u_w, s_w, idx_w;
    logic [SET_W-1:0] stride, pad_set;
    logic [SET_W-1:0] bit_addr, cat_set, cat_off;
    logic [SET_W-1:0] per, per_div, hyb_set, hyb_off;
    logic             u_gt_s;

    // Widen operands and guard divisors against zero.
    always_comb begin
        u_w    = (u == '0) ? SET_W'(1) : SET_W'(u);
        s_w    = (s == '0) ? SET_W'(1) : SET_W'(s);
        idx_w  = SET_W'(idx);
        u_gt_s = (u > s);
    end

    // Padded layout: whole-set stride per element.
    always_comb begin
        stride  = (u_w + s_w - SET_W'(1)) / s_w;
        pad_set = idx_w * stride;
    end

    // Packed layout: linear bit address split into set and offset.
    always_comb begin
        bit_addr = idx_w * u_w;
        cat_set  = bit_addr / s_w;
        cat_off  = bit_addr % s_w;
    end

    // Hybrid layout with small elements: p whole elements per set.
    always_comb begin
        per     = s_w / u_w;
        per_div = (per == '0) ? SET_W'(1) : per;
        hyb_set = idx_w / per_div;
        hyb_off = (idx_w % per_div) * u_w;
    end

    // Pick the start point for the requested policy.
    always_comb begin
        unique case (pol)
            POL_CAT: begin
                first_set = cat_set;
                first_off = SZ_W'(cat_off);
            end
            POL_HYB: begin
                first_set = u_gt_s ? pad_set : hyb_set;
                first_off = u_gt_s ? '0 : SZ_W'(hyb_off);
            end
            default: begin
                first_set = pad_set;
                first_off = '0;
            end
        endcase
    end
endmodule

// File: rtl/epag_walker.sv
// epag_walker: access sequencer shared by all policies.
// Starting from a loaded set and offset, it emits one access per cycle,
// each clipped to the set boundary and to the remaining element bits,
// until the whole element is covered. Assumes load only while idle and
// non-zero sizes at load time.
module epag_walker #(
    parameter int IDX_W    = 16,
    parameter int MAX_BITS = 64,
    localparam int SZ_W    = $clog2(MAX_BITS + 1),
    localparam int SET_W   = IDX_W + SZ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SET_W-1:0] first_set,
    input  logic [SZ_W-1:0]  first_off,
    input  logic [SZ_W-1:0]  u,
    input  logic [SZ_W-1:0]  s,
    output logic             busy,
    output logic [SET_W-1:0] cur_set,
    output logic [SZ_W-1:0]  cur_off,
    output logic [SZ_W-1:0]  count,
    output logic             last
);
    logic [SZ_W-1:0] rem;
    logic [SZ_W-1:0] s_lat;
    logic [SZ_W-1:0] room;

    // Bits available in this set versus bits still owed.
    always_comb begin
        room  = s_lat - cur_off;
        count = (rem < room) ? rem : room;
        last  = busy && (count == rem);
    end

    // Step through the spanned sets, one per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_set <= '0;
            cur_off <= '0;
            rem     <= '0;
            s_lat   <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            cur_set <= first_set;
            cur_off <= first_off;
            rem     <= u;
            s_lat   <= s;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                cur_set <= cur_set + SET_W'(1);
                cur_off <= '0;
                rem     <= rem - count;
            end
        end
    end

    // R4: every access is non-empty and ends inside its set.
    assert_fit_in_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count != '0) && ({1'b0, cur_off} + {1'b0, count} <= {1'b0, s_lat}));

    // R11: a non-final access is followed by the next set at offset zero.
    assert_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && cur_off == '0 && cur_set == $past(cur_set) + SET_W'(1)));

    // R8: the sequence ends right after the flagged access.
    assert_drop_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last) |=> !busy);
endmodule

// File: rtl/elem_pack_addr_gen.sv
// elem_pack_addr_gen: top of the element packing address generator.
// Accepts a start pulse while idle, validates the sizes, derives the
// first access from the policy and walks the remaining accesses.
// Assumes sizes in 1..MAX_BITS; zero sizes are rejected with size_err.
module elem_pack_addr_gen
    import epag_pkg::*;
#(
    parameter int IDX_W    = 16,
    parameter int MAX_BITS = 64,
    localparam int SZ_W    = $clog2(MAX_BITS + 1),
    localparam int OFF_W   = $clog2(MAX_BITS),
    localparam int SET_W   = IDX_W + SZ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [1:0]       policy,
    input  logic [SZ_W-1:0]  elem_bits,
    input  logic [SZ_W-1:0]  set_bits,
    output logic             acc_valid,
    output logic [SET_W-1:0] acc_set,
    output logic [OFF_W-1:0] acc_offset,
    output logic [SZ_W-1:0]  acc_count,
    output logic             acc_last,
    output logic             busy,
    output logic             size_err
);
    logic             zero_size, accept, reject;
    logic [SET_W-1:0] o_set;
    logic [SZ_W-1:0]  o_off, w_off, w_cnt;
    logic             w_busy, w_last;
    pack_pol_e        pol;

    // Decode the start request.
    always_comb begin
        pol       = pack_pol_e'(policy);
        zero_size = (elem_bits == '0) || (set_bits == '0);
        accept    = start && !w_busy && !zero_size;
        reject    = start && !w_busy && zero_size;
    end

    epag_origin #(.IDX_W(IDX_W), .MAX_BITS(MAX_BITS)) u_origin (
        .idx       (elem_idx),
        .pol       (pol),
        .u         (elem_bits),
        .s         (set_bits),
        .first_set (o_set),
        .first_off (o_off)
    );

    epag_walker #(.IDX_W(IDX_W), .MAX_BITS(MAX_BITS)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .first_set (o_set),
        .first_off (o_off),
        .u         (elem_bits),
        .s         (set_bits),
        .busy      (w_busy),
        .cur_set   (acc_set),
        .cur_off   (w_off),
        .count     (w_cnt),
        .last      (w_last)
    );

    // Sticky size error, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      size_err <= 1'b0;
        else if (reject) size_err <= 1'b1;
        else if (accept) size_err <= 1'b0;
    end

    // Drive the access outputs from the walker.
    always_comb begin
        busy       = w_busy;
        acc_valid  = w_busy;
        acc_offset = OFF_W'(w_off);
        acc_count  = w_cnt;
        acc_last   = w_last;
    end

    // R9: a sequence only begins after a start seen while idle.
    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    // R10: a zero size while idle flags an error and launches nothing.
    assert_zero_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (elem_bits == '0 || set_bits == '0)) |=> (size_err && !busy));
endmodule

// File: tb/elem_pack_addr_gen_bench.sv
// Scoreboard bench for elem_pack_addr_gen.
module elem_pack_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 16;
    localparam int MAX_BITS   = 64;
    localparam int SZ_W       = $clog2(MAX_BITS + 1);
    localparam int OFF_W      = $clog2(MAX_BITS);
    localparam int SET_W      = IDX_W + SZ_W;

    typedef struct {
        int    set;
        int    off;
        int    cnt;
        bit    last;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] elem_idx = '0;
    logic [1:0]       policy = 2'b00;
    logic [SZ_W-1:0]  elem_bits = '0;
    logic [SZ_W-1:0]  set_bits = '0;
    logic             acc_valid, acc_last, busy, size_err;
    logic [SET_W-1:0] acc_set;
    logic [OFF_W-1:0] acc_offset;
    logic [SZ_W-1:0]  acc_count;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    elem_pack_addr_gen #(.IDX_W(IDX_W), .MAX_BITS(MAX_BITS)) u_elem_pack_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .elem_idx   (elem_idx),
        .policy     (policy),
        .elem_bits  (elem_bits),
        .set_bits   (set_bits),
        .acc_valid  (acc_valid),
        .acc_set    (acc_set),
        .acc_offset (acc_offset),
        .acc_count  (acc_count),
        .acc_last   (acc_last),
        .busy       (busy),
        .size_err   (size_err)
    );

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Build the expected access list from the requirement formulas.
    task automatic push_expected(input int idx, input int pol, input int u,
                                 input int s, input string tag);
        int set, off, rem, c, k;
        k = (u + s - 1) / s;
        if (pol == 1) begin
            set = (idx * u) / s;
            off = (idx * u) % s;
        end else if (pol == 2 && u <= s) begin
            set = idx / (s / u);
            off = (idx % (s / u)) * u;
        end else begin
            set = idx * k;
            off = 0;
        end
        rem = u;
        while (rem > 0) begin
            c = (s - off < rem) ? s - off : rem;
            exp_q.push_back('{set: set, off: off, cnt: c, last: (c == rem), tag: tag});
            rem -= c;
            set++;
            off = 0;
        end
    endtask

    task automatic pulse(input int idx, input int pol, input int u, input int s);
        @(negedge clk);
        elem_idx  = IDX_W'(idx);
        policy    = 2'(pol);
        elem_bits = SZ_W'(u);
        set_bits  = SZ_W'(s);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    // Run one element and confirm the scoreboard drained.
    task automatic run_op(input int idx, input int pol, input int u,
                          input int s, input string tag);
        push_expected(idx, pol, u, s, tag);
        pulse(idx, pol, u, s);
        while (busy) @(negedge clk);
        check(exp_q.size() == 0,
              $sformatf("%s leftover accesses actual=%0d expected=0", tag, exp_q.size()));
    endtask

    // Monitor: compare each presented access against the queue head.
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, $sformatf("R11 unexpected access set=%0d off=%0d cnt=%0d expected=none",
                                      acc_set, acc_offset, acc_count));
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(int'(acc_set) == e.set && int'(acc_offset) == e.off &&
                      int'(acc_count) == e.cnt && acc_last == e.last,
                      $sformatf("%s actual set=%0d off=%0d cnt=%0d last=%0d expected set=%0d off=%0d cnt=%0d last=%0d",
                                e.tag, acc_set, acc_offset, acc_count, acc_last,
                                e.set, e.off, e.cnt, e.last));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !acc_valid && !acc_last && !size_err,
              $sformatf("R1 reset actual busy=%0d valid=%0d last=%0d err=%0d expected 0",
                        busy, acc_valid, acc_last, size_err));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !size_err, "R1 after reset release expected idle");

        // R2: equal sizes under each policy
        for (int p = 0; p < 4; p++) run_op(5, p, 32, 32, "R2");
        run_op(0, 1, 64, 64, "R2");

        // R3: padded with remainder, and the reserved code
        run_op(3, 0, 40, 16, "R3");
        run_op(2, 3, 17, 8, "R3");

        // R4: packed with multi-set straddles
        run_op(2, 1, 20, 7, "R4");
        run_op(1, 1, 64, 8, "R4");
        run_op(1000, 1, 13, 64, "R4");

        // R5: packed access count varies with index
        run_op(0, 1, 24, 32, "R5");
        run_op(1, 1, 24, 32, "R5");
        run_op(4, 1, 24, 32, "R5");

        // R6: hybrid with small elements
        run_op(7, 2, 10, 32, "R6");
        run_op(65535, 2, 1, 64, "R6");

        // R7: hybrid with large elements matches padded
        run_op(3, 2, 40, 16, "R7");

        // R9: start during busy is ignored
        push_expected(1, 0, 48, 16, "R9");
        pulse(1, 0, 48, 16);
        elem_idx = IDX_W'(9);
        policy   = 2'b01;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R9 leftover accesses");
        repeat (2) @(negedge clk);
        check(!busy, $sformatf("R9 actual busy=%0d expected=0", busy));

        // R10: zero sizes flag an error and produce nothing
        pulse(4, 0, 0, 16);
        check(size_err && !busy, $sformatf("R10 U=0 actual err=%0d busy=%0d expected 1/0", size_err, busy));
        repeat (3) @(negedge clk);
        check(size_err, "R10 error flag should stay set");
        pulse(4, 1, 16, 0);
        check(size_err && !busy, $sformatf("R10 S=0 actual err=%0d busy=%0d expected 1/0", size_err, busy));
        run_op(4, 0, 16, 16, "R10");
        check(!size_err, $sformatf("R10 clear actual err=%0d expected=0", size_err));

        // R8 / R11: idle after last access
        run_op(6, 1, 33, 16, "R8");
        check(!busy && !acc_valid, "R8 idle after last access");

        done = 1'b1;
        finish_run();
    end
endmodule